// File: doc/BRIEF.md
# Hot-Swap Gate Control Sequencer

This block sits in the digital core of a hot-swap power path. Comparators outside the block watch the input supply and the pass transistor. They report five conditions: input below the low undervoltage trip, input above the high undervoltage trip, input overvoltage, drain below its threshold, and gate drive close to its rail. The block also takes two active-low commands. The first is a shutdown level. The second is a restart request that acts on its falling edge. From these inputs the block decides whether the gate may be driven and reports power-good, supply-good and a latched retry-exhausted alert.

Each overvoltage onset and each shutdown assertion counts as one event. When the count reaches a limit, the gate is held off and the alert latches low. Releasing shutdown does not clear this condition. Two things empty the counter: power-good held without a break for a whole window, or an undervoltage toggle, which is a drop below the low trip followed by a rise above the high trip. The toggle also clears the alert. A restart request turns the gate off for a fixed time and then lets it come back on. All timing is counted in millisecond ticks from a clock prescaler.

Top module: `hotswap_seq`

## Requirements
- R1: When the low undervoltage comparator is high, an undervoltage fault is set and the gate output goes low.
- R2: The undervoltage fault clears only when the high comparator is high and the low comparator is low. While both comparators are low, the fault keeps its previous state (hysteresis). The fault is set out of reset.
- R3: While the overvoltage comparator is high, the gate output is low.
- R4: `pgood_n_o` is low only while the gate is enabled and both the drain-low and gate-rail inputs are high. In every other case it is high.
- R5: While `shdn_n_i` is low, the gate is off. When it is released, the gate turns back on if no fault is present and the retry limit has not been reached.
- R6: Each rising edge of overvoltage and each falling edge of `shdn_n_i` adds one event. When the count equals MAX_EVENTS, `retry_alert_n_o` goes low and the gate stays off. Neither releasing shutdown nor further events clear this state.
- R7: Power-good held without a break for WINDOW_MS milliseconds returns the event count to zero.
- R8: An undervoltage fault clearing (R2) sets the event count to zero and releases `retry_alert_n_o` high. If an event arrives in the same cycle, the clear wins.
- R9: A falling edge on `restart_n_i` turns the gate off for RESTART_MS milliseconds (to within one tick). The gate then turns back on, even if the input is still held low.
- R10: A restart falling edge that arrives while the restart timer is running is ignored. If a fault is present when the timer ends, the gate stays off.
- R11: `supply_ok_o` is high exactly when there is no undervoltage fault and no overvoltage.
- R12: Out of reset, the gate is off, `pgood_n_o` is high, `supply_ok_o` is low and `retry_alert_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uv_lo_i | input | 1 | Input below low undervoltage trip |
| uv_hi_i | input | 1 | Input above high undervoltage trip |
| ov_i | input | 1 | Input above overvoltage trip |
| drain_low_i | input | 1 | Drain below its on-threshold |
| gate_rail_i | input | 1 | Gate drive near its rail |
| shdn_n_i | input | 1 | Shutdown command, level, active low |
| restart_n_i | input | 1 | Restart request, falling edge |
| gate_en_o | output | 1 | Gate drive enable |
| pgood_n_o | output | 1 | Power-good, low when good (open-drain style) |
| supply_ok_o | output | 1 | Input supply inside its window |
| retry_alert_n_o | output | 1 | Retry limit reached, low and latched |

## Verification
The bench builds the block with TICKS_PER_MS=4, RESTART_MS=12, WINDOW_MS=20 and MAX_EVENTS=4. With these values a full restart period lasts about fifty cycles, and the power-good window about eighty. The retry limit can therefore be reached, cleared and reached again within a short run. Under this configuration the bench walks through all 32 combinations of the five comparator inputs. It keeps its own arithmetic model of the hysteresis and the event count, so that overvoltage onsets accumulate into exhaustion and undervoltage toggles empty the count along the way. Separate directed runs then place restart edges before and after the timer ends, and shutdown pulses on either side of the window expiry.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Raw comparator and command inputs, grouped for one synchronizer bank.
  typedef struct packed {
    logic uv_lo;
    logic uv_hi;
    logic ov;
    logic drain_low;
    logic gate_rail;
    logic shdn_n;
    logic restart_n;
  } hs_raw_t;

  localparam int HS_W = $bits(hs_raw_t);

  // Benign levels: active-low commands idle high, comparators idle low.
  localparam hs_raw_t HS_IDLE = '{uv_lo: 1'b0, uv_hi: 1'b0, ov: 1'b0,
                                  drain_low: 1'b0, gate_rail: 1'b0,
                                  shdn_n: 1'b1, restart_n: 1'b1};

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] r_q;
    logic [W-1:0] r_d;
    if (g == 0) begin : g_first
      assign r_d = d_i;
    end else begin : g_next
      assign r_d = g_stage[g-1].r_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= RST_VAL;
      else        r_q <= r_d;
    end
  end

  assign q_o = g_stage[STAGES-1].r_q;

endmodule

// File: rtl/hs_tick.sv
module hs_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  if (DIV <= 1) begin : g_every
    assign tick_o = 1'b1;
  end else begin : g_div
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wrap;

    assign wrap = (cnt_q == LAST);

    always_comb begin
      cnt_d = cnt_q + 1'b1;
      if (wrap) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign tick_o = wrap;
  end

endmodule

// File: rtl/hs_ms_timer.sv
module hs_ms_timer #(
  parameter int MS_COUNT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic tick_i,
  output logic busy_o
);

  localparam int CW = $clog2(MS_COUNT + 1);
  localparam logic [CW-1:0] START = CW'(MS_COUNT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_en;

  assign run_en = tick_i && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = START;
    else if (run_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/hs_retry.sv
module hs_retry #(
  parameter int MAX_EVENTS = 7,
  parameter int WINDOW_MS  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic event_i,
  input  logic clear_i,
  input  logic pgood_i,
  output logic exhausted_o
);

  localparam int CW = $clog2(MAX_EVENTS + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAX_EVENTS);

  logic [CW-1:0] count_q, count_d, base;
  logic          win_busy, win_done, exhausted;

  // Window timer reloads whenever power-good is absent.
  hs_ms_timer #(.MS_COUNT(WINDOW_MS)) i_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (!pgood_i),
    .tick_i (tick_i),
    .busy_o (win_busy)
  );

  assign exhausted = (count_q == CMAX);
  assign win_done  = pgood_i && !win_busy && !exhausted;

  always_comb begin
    base    = win_done ? '0 : count_q;
    count_d = base;
    if (event_i && !exhausted) count_d = base + 1'b1;
    if (clear_i)               count_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign exhausted_o = exhausted;

endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int TICKS_PER_MS = 50000,
  parameter int WINDOW_MS    = 10000,
  parameter int RESTART_MS   = 10000,
  parameter int MAX_EVENTS   = 7,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_lo_i,
  input  logic uv_hi_i,
  input  logic ov_i,
  input  logic drain_low_i,
  input  logic gate_rail_i,
  input  logic shdn_n_i,
  input  logic restart_n_i,
  output logic gate_en_o,
  output logic pgood_n_o,
  output logic supply_ok_o,
  output logic retry_alert_n_o
);

  import hs_pkg::*;

  // Reset: asserted at once, released after two clocks.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Input synchronization
  hs_raw_t          raw, syn;
  logic [HS_W-1:0]  syn_bits;

  assign raw = '{uv_lo: uv_lo_i, uv_hi: uv_hi_i, ov: ov_i,
                 drain_low: drain_low_i, gate_rail: gate_rail_i,
                 shdn_n: shdn_n_i, restart_n: restart_n_i};

  hs_sync #(.W(HS_W), .STAGES(SYNC_STAGES), .RST_VAL(HS_IDLE)) i_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (raw),
    .q_o   (syn_bits)
  );
  assign syn = hs_raw_t'(syn_bits);

  logic uv_lo_s, uv_hi_s, ov_s, drain_s, rail_s, shdn_s, restart_s;
  assign uv_lo_s   = syn.uv_lo;
  assign uv_hi_s   = syn.uv_hi;
  assign ov_s      = syn.ov;
  assign drain_s   = syn.drain_low;
  assign rail_s    = syn.gate_rail;
  assign shdn_s    = syn.shdn_n;
  assign restart_s = syn.restart_n;

  // Millisecond tick
  logic ms_tick;
  hs_tick #(.DIV(TICKS_PER_MS)) i_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (ms_tick)
  );

  // State registers
  logic uv_fault_q, uv_fault_d;
  logic ov_prev_q, shdn_prev_q, restart_prev_q;
  logic gate_en_q, pgood_q, supply_q;

  // Next-state logic
  logic uv_clear, ov_rise, shdn_fall, restart_fall, restart_load;
  logic restart_busy, exhausted, gate_ok, pgood_d, supply_d;

  always_comb begin
    uv_fault_d = uv_fault_q;
    if (uv_lo_s)      uv_fault_d = 1'b1;
    else if (uv_hi_s) uv_fault_d = 1'b0;
  end

  assign uv_clear     = uv_fault_q && !uv_fault_d;
  assign ov_rise      = ov_s && !ov_prev_q;
  assign shdn_fall    = !shdn_s && shdn_prev_q;
  assign restart_fall = !restart_s && restart_prev_q;
  assign restart_load = restart_fall && !restart_busy;

  hs_ms_timer #(.MS_COUNT(RESTART_MS)) i_restart (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (restart_load),
    .tick_i (ms_tick),
    .busy_o (restart_busy)
  );

  hs_retry #(.MAX_EVENTS(MAX_EVENTS), .WINDOW_MS(WINDOW_MS)) i_retry (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick_i      (ms_tick),
    .event_i     (ov_rise || shdn_fall),
    .clear_i     (uv_clear),
    .pgood_i     (pgood_q),
    .exhausted_o (exhausted)
  );

  assign gate_ok  = !uv_fault_q && !ov_s && shdn_s && !restart_busy && !exhausted;
  assign pgood_d  = gate_ok && drain_s && rail_s;
  assign supply_d = !uv_fault_q && !ov_s;

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      uv_fault_q     <= 1'b1;
      ov_prev_q      <= 1'b0;
      shdn_prev_q    <= 1'b1;
      restart_prev_q <= 1'b1;
      gate_en_q      <= 1'b0;
      pgood_q        <= 1'b0;
      supply_q       <= 1'b0;
    end else begin
      uv_fault_q     <= uv_fault_d;
      ov_prev_q      <= ov_s;
      shdn_prev_q    <= shdn_s;
      restart_prev_q <= restart_s;
      gate_en_q      <= gate_ok;
      pgood_q        <= pgood_d;
      supply_q       <= supply_d;
    end
  end

  assign gate_en_o       = gate_en_q;
  assign pgood_n_o       = !pgood_q;
  assign supply_ok_o     = supply_q;
  assign retry_alert_n_o = !exhausted;

endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic uv_fault,
  input logic uv_hi_s,
  input logic uv_clear,
  input logic ov_s,
  input logic shdn_s,
  input logic drain_s,
  input logic rail_s,
  input logic restart_busy,
  input logic gate_en_o,
  input logic pgood_n_o,
  input logic supply_ok_o,
  input logic retry_alert_n_o
);

  AST_UV_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |=> !gate_en_o); // R1

  AST_UV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault && !uv_hi_s |=> uv_fault); // R2

  AST_OV_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ov_s |=> !gate_en_o); // R3

  AST_PGOOD_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood_n_o |-> gate_en_o); // R4

  AST_PGOOD_NEEDS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !pgood_n_o |-> $past(drain_s && rail_s)); // R4

  AST_SHDN_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_s |=> !gate_en_o); // R5

  AST_ALERT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !retry_alert_n_o && !uv_clear |=> !retry_alert_n_o); // R6

  AST_ALERT_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !retry_alert_n_o |=> !gate_en_o); // R6

  AST_UV_CLEAR_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    uv_clear |=> retry_alert_n_o); // R8

  AST_RESTART_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    restart_busy |=> !gate_en_o); // R9

  AST_SUPPLY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok_o |-> !$past(ov_s) && !$past(uv_fault)); // R11

endmodule

bind hotswap_seq hs_seq_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .uv_fault        (uv_fault_q),
  .uv_hi_s         (uv_hi_s),
  .uv_clear        (uv_clear),
  .ov_s            (ov_s),
  .shdn_s          (shdn_s),
  .drain_s         (drain_s),
  .rail_s          (rail_s),
  .restart_busy    (restart_busy),
  .gate_en_o       (gate_en_o),
  .pgood_n_o       (pgood_n_o),
  .supply_ok_o     (supply_ok_o),
  .retry_alert_n_o (retry_alert_n_o)
);

// File: tb/test_hotswap_seq.sv
module test_hotswap_seq;

  localparam int TPM  = 4;
  localparam int WMS  = 20;
  localparam int RMS  = 12;
  localparam int MAXE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_lo = 1'b0, uv_hi = 1'b0, ov = 1'b0, drain = 1'b0, rail = 1'b0;
  logic shdn_n = 1'b1, restart_n = 1'b1;
  logic gate_en, pgood_n, supply_ok, alert_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hotswap_seq #(.TICKS_PER_MS(TPM), .WINDOW_MS(WMS), .RESTART_MS(RMS),
                .MAX_EVENTS(MAXE), .SYNC_STAGES(2)) i_hotswap_seq (
    .clk (clk), .rst_n (rst_n),
    .uv_lo_i (uv_lo), .uv_hi_i (uv_hi), .ov_i (ov),
    .drain_low_i (drain), .gate_rail_i (rail),
    .shdn_n_i (shdn_n), .restart_n_i (restart_n),
    .gate_en_o (gate_en), .pgood_n_o (pgood_n),
    .supply_ok_o (supply_ok), .retry_alert_n_o (alert_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic uv_toggle();
    uv_lo = 1'b1; uv_hi = 1'b0; step(6);
    uv_lo = 1'b0; uv_hi = 1'b1; step(8);
  endtask

  task automatic shdn_pulse();
    shdn_n = 1'b0; step(8);
    shdn_n = 1'b1; step(8);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(6);
    // R12 reset state
    chk("R12", "gate_en", gate_en, 1'b0);
    chk("R12", "pgood_n", pgood_n, 1'b1);
    chk("R12", "supply_ok", supply_ok, 1'b0);
    chk("R12", "alert_n", alert_n, 1'b1);

    // Sweep of all comparator combinations against an arithmetic model
    begin
      logic m_uvf, m_pov, m_nuvf, m_gate;
      int m_cnt;
      m_uvf = 1'b1; m_pov = 1'b0; m_cnt = 0;
      for (int p = 0; p < 32; p++) begin
        uv_lo = p[4]; uv_hi = p[3]; ov = p[2]; drain = p[1]; rail = p[0];
        step(8);
        m_nuvf = uv_lo ? 1'b1 : (uv_hi ? 1'b0 : m_uvf);
        if (m_uvf && !m_nuvf)               m_cnt = 0;
        else if (ov && !m_pov && m_cnt < MAXE) m_cnt++;
        m_uvf = m_nuvf; m_pov = ov;
        m_gate = !m_uvf && !ov && (m_cnt != MAXE);
        chk("R1 R3 R6", "gate_en sweep", gate_en, m_gate);
        chk("R4", "pgood_n sweep", pgood_n, !(m_gate && drain && rail));
        chk("R2 R11", "supply_ok sweep", supply_ok, !m_uvf && !ov);
        chk("R6 R8", "alert_n sweep", alert_n, m_cnt != MAXE);
      end
    end
    ov = 1'b0;

    // R9 restart timing, one cycle per edge
    uv_toggle();
    drain = 1'b1; rail = 1'b1; step(4);
    chk("R9", "gate on before restart", gate_en, 1'b1);
    chk("R4", "pgood_n low when good", pgood_n, 1'b0);
    restart_n = 1'b0;
    step(6);
    chk("R9", "gate off after restart edge", gate_en, 1'b0);
    chk("R4", "pgood_n released in restart", pgood_n, 1'b1);
    step((RMS - 1) * TPM - 6);
    chk("R9", "gate still off near end", gate_en, 1'b0);
    step(TPM + 10);
    chk("R9", "gate back after restart", gate_en, 1'b1);
    step(RMS * TPM + 20);
    chk("R9", "held low gives one cycle", gate_en, 1'b1);
    restart_n = 1'b1; step(8);

    // R10 second edge ignored while running
    restart_n = 1'b0; step(24);
    restart_n = 1'b1; step(4);
    restart_n = 1'b0; step(30);
    chk("R10", "second edge ignored", gate_en, 1'b1);
    restart_n = 1'b1; step(RMS * TPM + 20);

    // R10 fault present at expiry
    restart_n = 1'b0; step(20);
    ov = 1'b1; step(38);
    chk("R10", "fault at expiry keeps gate off", gate_en, 1'b0);
    ov = 1'b0; step(8);
    chk("R10", "gate on after fault removed", gate_en, 1'b1);
    restart_n = 1'b1; step(8);

    // R5 and R6 shutdown events up to the limit
    uv_toggle();
    for (int k = 1; k <= MAXE; k++) begin
      shdn_n = 1'b0; step(8);
      chk("R5", "gate off in shutdown", gate_en, 1'b0);
      shdn_n = 1'b1; step(8);
      chk("R5 R6", "gate after release", gate_en, k < MAXE);
      chk("R6", "alert_n after event", alert_n, k < MAXE);
    end
    shdn_pulse();
    chk("R6", "alert stays latched", alert_n, 1'b0);
    chk("R6", "gate stays off latched", gate_en, 1'b0);

    // R8 undervoltage toggle clears the latch
    uv_toggle();
    chk("R8", "alert_n after uv toggle", alert_n, 1'b1);
    chk("R8", "gate on after uv toggle", gate_en, 1'b1);

    // R7 window of power-good clears the count
    for (int k = 0; k < MAXE - 1; k++) shdn_pulse();
    chk("R7", "alert_n before window", alert_n, 1'b1);
    step(WMS * TPM + 20);
    for (int k = 0; k < MAXE - 1; k++) shdn_pulse();
    chk("R7", "count cleared by window", alert_n, 1'b1);
    chk("R7", "gate on after window", gate_en, 1'b1);
    shdn_pulse();
    chk("R7", "counting resumes after clear", alert_n, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule